// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block is a watchdog timer that sits on a simple write bus. It has one 8-bit control and status register. A free-running timeout counter advances on a slow tick-enable input. When it expires it can set an interrupt flag and drive an interrupt request, pulse a reset request, or both. Software restarts the count with a clear strobe, which stands for the watchdog-reset instruction.

The prescaler and the watchdog enable are guarded. One write must set both the change-enable bit and the watchdog-enable bit. That write opens a short window, and only the next write inside it may change the prescaler or clear the watchdog enable. Writes outside the window leave the prescaler untouched, and report no error.

Two small state machines do the work:
- The window machine has the states `W_LOCKED` and `W_OPEN`.
  - Transition *unlock* goes from `W_LOCKED` to `W_OPEN`.
  - Transition *commit* is a guarded write, and transition *lapse* is the end of the window. Both return to `W_LOCKED`.
- The timer machine has the states `T_IDLE` and `T_RUN`.
  - Transition *arm* goes from `T_IDLE` to `T_RUN` when either enable is set.
  - Transition *disarm* goes back to `T_IDLE` when both enables are clear.

Top module: `wdt_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, and irq and rst_req are low.
- R2: rd_data shows the current register contents with this bit layout:
  - bit 7: timeout flag.
  - bit 6: interrupt enable.
  - bit 5: prescaler bit 3.
  - bit 4: window open.
  - bit 3: watchdog enable.
  - bits 2:0: prescaler bits 2:0.
  A write of 0x40 while locked reads back as 0x40.
- R3: A write opens the window only when it is made while locked and sets both bit 4 and bit 3 (for example 0x58). A write that sets bit 4 without bit 3 (for example 0x50) leaves bit 4 reading 0.
- R4: The window lasts WIN_CYCLES cycles (default 4).
  - While open, bit 4 reads 1.
  - The first write made in any of the WIN_CYCLES cycles after the unlocking write is accepted. It loads the prescaler, the interrupt enable and the watchdog enable, and it closes the window.
  - If no write comes, the window closes after WIN_CYCLES cycles. A write one cycle later is an ordinary write.
- R5: A write made while the window is closed leaves the prescaler field (bits 5 and 2:0) unchanged.
- R6: A write made while the window is closed cannot clear the watchdog enable, but it can set it. The interrupt enable takes bit 6 on every write.
- R7: The timeout is BASE_TICKS × 2^code tick-enable cycles, where code is the 4-bit prescaler.
  - Code 0 gives BASE_TICKS.
  - Code 4 gives 16 × BASE_TICKS.
  - Codes above MAX_CODE (9) act as code 9.
- R8: With the interrupt enable set and the watchdog enable clear, an expiry sets the flag and raises irq, and rst_req stays low.
- R9: With the watchdog enable set, an expiry pulses rst_req high for exactly one cycle. If the interrupt enable is clear, irq stays low.
- R10: A cycle with kick high restarts the count from zero, so the next expiry comes a full timeout after the kick.
- R11: The flag (bit 7) clears when a write has bit 7 set or when irq_ack is high. If an expiry lands in the same cycle, the expiry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Slow timer tick enable |
| kick | input | 1 | Counter-clear strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| irq_ack | input | 1 | Clears the timeout flag |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Interrupt request (flag AND interrupt enable) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the edge of the guarded window.
- One run writes exactly WIN_CYCLES cycles after the unlock, and the write must be accepted.
- Another run writes one cycle later, and the write must be ignored.

The bench spaces writes with counted idle cycles after an unlocking write to hit each case, and reads bit 4 at both points. A table of back-to-back writes covers the other paths, with kick held so that no expiry disturbs the readback:
- unlocks with the watchdog enable missing,
- guarded writes while locked,
- the sticky watchdog enable.

Expiry timing for each prescaler code, including a reserved code, is measured in cycles from a kick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CODE_W    = 4;
    localparam int B_FLAG    = 7;
    localparam int B_IE      = 6;
    localparam int B_CODE3   = 5;
    localparam int B_CHG     = 4;
    localparam int B_WDE     = 3;

    typedef enum logic {W_LOCKED, W_OPEN} win_state_t;
    typedef enum logic {T_IDLE, T_RUN} tmr_state_t;

    typedef struct packed {
        logic              flag;
        logic              ie;
        logic              wde;
        logic [CODE_W-1:0] code;
    } wdt_reg_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic unlock_req,
    output logic win_open,
    output logic prot_wr
);
    localparam int WCW = $clog2(WIN_CYCLES + 1);

    win_state_t     state_q, state_d;
    logic [WCW-1:0] cnt_q;
    logic           last_cyc;

    assign last_cyc = (cnt_q == WCW'(WIN_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == W_LOCKED) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_LOCKED: if (wr_en && unlock_req) state_d = W_OPEN;   // unlock
            W_OPEN:   if (wr_en || last_cyc)   state_d = W_LOCKED; // commit / lapse
            default:  state_d = W_LOCKED;
        endcase
    end

    always_comb begin
        win_open = 1'b0;
        prot_wr  = 1'b0;
        unique case (state_q)
            W_LOCKED: begin
                win_open = 1'b0;
                prot_wr  = 1'b0;
            end
            W_OPEN: begin
                win_open = 1'b1;
                prot_wr  = wr_en;
            end
            default: begin
                win_open = 1'b0;
                prot_wr  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wdt_tmr.sv
module wdt_tmr
    import wdt_pkg::*;
#(
    parameter int BASE_TICKS = 2048,
    parameter int MAX_CODE   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              kick,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    localparam int CW = $clog2(BASE_TICKS) + MAX_CODE + 1;

    tmr_state_t        state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     limit;
    logic [CODE_W-1:0] code_eff;
    logic              at_end;

    assign code_eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    assign limit    = CW'(BASE_TICKS) << code_eff;
    assign at_end   = (cnt_q >= limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:  if (run)  state_d = T_RUN;   // arm
            T_RUN:   if (!run) state_d = T_IDLE;  // disarm
            default: state_d = T_IDLE;
        endcase
    end

    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            T_IDLE:  expire = 1'b0;
            T_RUN:   expire = tick && !kick && at_end;
            default: expire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == T_IDLE || kick) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int BASE_TICKS = 2048,
    parameter int MAX_CODE   = 9,
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       kick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       irq_ack,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       rst_req
);
    wdt_reg_t reg_q;
    logic     win_open, prot_wr, expire, unlock_req, flag_clr;

    assign unlock_req = wr_data[B_CHG] && wr_data[B_WDE];
    assign flag_clr   = (wr_en && wr_data[B_FLAG]) || irq_ack;

    wdt_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .unlock_req (unlock_req),
        .win_open   (win_open),
        .prot_wr    (prot_wr)
    );

    wdt_tmr #(.BASE_TICKS(BASE_TICKS), .MAX_CODE(MAX_CODE)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .run    (reg_q.ie || reg_q.wde),
        .kick   (kick),
        .code   (reg_q.code),
        .expire (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire && reg_q.wde;
            if (expire) begin
                reg_q.flag <= 1'b1;
            end else if (flag_clr) begin
                reg_q.flag <= 1'b0;
            end
            if (wr_en) begin
                reg_q.ie <= wr_data[B_IE];
            end
            if (prot_wr) begin
                reg_q.wde  <= wr_data[B_WDE];
                reg_q.code <= {wr_data[B_CODE3], wr_data[2:0]};
            end else if (wr_en && wr_data[B_WDE]) begin
                reg_q.wde <= 1'b1;
            end
        end
    end

    assign rd_data = {reg_q.flag, reg_q.ie, reg_q.code[3], win_open,
                      reg_q.wde, reg_q.code[2:0]};
    assign irq     = reg_q.flag && reg_q.ie;
endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk #(
    parameter int WIN_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       rst_req
);
    localparam int RW = $clog2(WIN_CYCLES + 2) + 1;
    logic [RW-1:0] open_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_run <= '0;
        end else if (rd_data[4]) begin
            open_run <= open_run + 1'b1;
        end else begin
            open_run <= '0;
        end
    end

    p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        open_run <= RW'(WIN_CYCLES));

    p_no_unlock_without_wde_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[3] && !rd_data[4]) |=> !rd_data[4]);

    p_presc_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |=> ({rd_data[5], rd_data[2:0]} == $past({rd_data[5], rd_data[2:0]})));

    p_wde_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] && !rd_data[4]) |=> rd_data[3]);

    p_rst_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_rst_needs_wde_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(rd_data[3]));
endmodule

bind wdt_ctrl wdt_ctrl_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rst_req (rst_req)
);

// File: tb/sim_wdt_ctrl.sv
module sim_wdt_ctrl;
    localparam int BASE = 8;
    localparam int NV   = 12;
    // {write data, expected readback}, applied on consecutive cycles, kick held
    localparam logic [15:0] VEC [NV] = '{
        16'h4040, 16'h4440, 16'h5040, 16'h4440, 16'h5858, 16'h4444,
        16'h4144, 16'h585C, 16'h4747, 16'h181F, 16'h2929, 16'h4069
    };

    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, kick = 1'b0;
    logic       wr_en = 1'b0, irq_ack = 1'b0, irq, rst_req;
    logic [7:0] wr_data = '0, rd_data;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    wdt_ctrl #(.BASE_TICKS(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
        .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
        .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0:          return "R2";
            2:          return "R3";
            4, 7, 9:    return "R3";
            5, 8, 10:   return "R4";
            1, 3, 6:    return "R5";
            default:    return "R6";
        endcase
    endfunction

    // kick + ack, then count cycles until irq or rst_req
    task automatic measure(input int exp_n, input bit want_rst, input string tag);
        int n = 0;
        kick = 1'b1; irq_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        kick = 1'b0; irq_ack = 1'b0;
        while (!(irq || rst_req) && n < 20000) begin
            @(negedge clk); n++;
        end
        chk(n == exp_n, tag, n, exp_n);
        if (want_rst) begin
            chk(rst_req == 1'b1 && irq == 1'b0, "R9 rst_req only", {irq, rst_req}, 1);
            @(negedge clk);
            chk(rst_req == 1'b0, "R9 one-cycle pulse", rst_req, 0);
        end else begin
            chk(irq == 1'b1 && rst_req == 1'b0, "R8 irq only", {irq, rst_req}, 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(2);
        chk(rd_data == 8'h00 && irq == 0 && rst_req == 0, "R1 reset state",
            {rd_data, irq, rst_req}, 0);
        rst_n = 1'b1;
        idle(1);
        chk(rd_data == 8'h00, "R1 after reset release", rd_data, 0);

        // table walk
        kick = 1'b1;
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][15:8]);
            chk(rd_data == VEC[i][7:0], tag_of(i), rd_data, VEC[i][7:0]);
        end
        kick = 1'b0;

        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);

        // R4 window boundary: last accepted cycle
        wr(8'h58);
        chk(rd_data[4] == 1'b1, "R4 window open", rd_data, 8'h58);
        idle(3);
        chk(rd_data[4] == 1'b1, "R4 still open at last cycle", rd_data[4], 1);
        wr(8'h41);
        chk(rd_data[4] == 0 && rd_data[3] == 0 && rd_data[2:0] == 3'd1,
            "R4 write at last cycle accepted", rd_data & 8'h3F, 8'h01);
        // one cycle too late
        wr(8'h58);
        idle(4);
        chk(rd_data[4] == 1'b0, "R4 window lapsed", rd_data[4], 0);
        wr(8'h43);
        chk(rd_data[2:0] == 3'd1 && rd_data[5] == 0, "R5 late write ignored",
            rd_data & 8'h27, 8'h01);
        chk(rd_data[3] == 1'b1, "R6 wde kept by late write", rd_data[3], 1);

        // timeouts, interrupt only
        wr(8'h58); wr(8'h40);
        measure(BASE, 1'b0, "R7 code0 timeout");
        chk(rd_data[7] == 1'b1, "R8 flag set", rd_data[7], 1);
        wr(8'h58); wr(8'h44);
        measure(BASE * 16, 1'b0, "R7 code4 timeout");
        wr(8'h58); wr(8'h64);
        measure(BASE * 512, 1'b0, "R7 reserved code clamps to 9");

        // R11 clear by ack and by write-one
        irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0 && rd_data[7] == 1'b0, "R11 ack clears flag", rd_data, 8'h64);

        // R10 kick restarts
        wr(8'h58); wr(8'h44);
        kick = 1'b1; @(posedge clk); @(negedge clk); kick = 1'b0;
        idle(100);
        chk(irq == 1'b0, "R10 no irq before restart", irq, 0);
        measure(BASE * 16, 1'b0, "R10 full timeout after kick");
        wr(8'hC0);
        chk(rd_data[7] == 1'b0 && irq == 1'b0, "R11 write-one clears flag", rd_data, 8'h44);

        // R9 watchdog enable only
        wr(8'h58); wr(8'h08);
        measure(BASE, 1'b1, "R9 reset timeout");
        chk(rd_data[7] == 1'b1 && irq == 1'b0, "R9 flag set, irq low", {rd_data[7], irq}, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule